// File: doc/BRIEF.md
# Programmable LCD Raster Timing Generator

This block produces the raster timing for a parallel RGB TFT panel from a pixel clock. A set of configuration inputs describes the active width and height, the horizontal front porch, sync width and back porch, the vertical back porch, front porch and sync width, and a polarity inversion for each sync output. From these the block drives a line sync, a frame sync, a data-enable strobe, the pixel and line coordinates of the current active pixel, and a 24-bit colour bus.

Pixels come from an upstream source over a request/valid pair. The block raises its request one clock before each data-enable cycle. If the source has no pixel ready, black goes out and a sticky starvation flag is set. Configuration inputs are copied into a working set only on the final clock of a frame, so a frame never mixes two timings. A typical panel is 480 by 272 at a 9 MHz pixel clock.

Panels that use only data-enable ignore the sync lines, but the total horizontal and vertical blanking must still match the panel. A configuration with both porches set to zero and all blanking held in the sync widths is fully supported.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is high and on the first clock after it is released, data-enable is low, both syncs are inactive, the colour bus is zero, the coordinates are zero and the starvation flag is clear. The counters then start at pixel 0 of line 0.
- R2: A line is made of these spans, in this order: the active pixels, then (front porch field + 1) clocks, then (line sync field + 1) clocks with line sync active, then (back porch field + 1) clocks.
- R3: A frame is made of these spans, in this order: the vertical back porch field taken as-is (0 to 255 lines), the active lines, the vertical front porch field taken as-is, then (frame sync field + 1) lines with frame sync active on every clock of those lines.
- R4: Data-enable is high exactly on the active pixels of the active lines. During data-enable, pos_x gives the pixel index and pos_y the active line index. Both are zero otherwise.
- R5: pix_req is high exactly one clock before each data-enable clock. This includes the first pixel of a frame that uses a newly loaded configuration.
- R6: The colour bus holds the pixel accepted on the previous clock, with blue in bits 7:0, green in bits 15:8 and red in bits 23:16. It is zero whenever data-enable is low.
- R7: When pix_req is high and pix_valid is low, the next data-enable clock outputs zero colour and the starvation flag goes high. The flag then stays high until reset.
- R8: Both syncs are active low when their inversion input is 0 and active high when it is 1. The inversion takes effect at once.
- R9: A configuration change during a frame leaves that frame unchanged. The new values are taken on the last clock of the last frame sync line.
- R10: A data-enable-only setting with all porch fields at zero, line sync field 42 and frame sync field 15 gives 45 blank clocks between lines and 16 blank lines between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_h_active | input | 11 | Active pixels per line |
| cfg_v_active | input | 10 | Active lines per frame |
| cfg_hfp | input | 10 | Horizontal front porch minus one |
| cfg_hsw | input | 6 | Line sync width minus one |
| cfg_hbp | input | 8 | Horizontal back porch minus one |
| cfg_vfp | input | 8 | Vertical front porch in lines |
| cfg_vsw | input | 6 | Frame sync width minus one |
| cfg_vbp | input | 8 | Vertical back porch in lines |
| cfg_line_sync_inv | input | 1 | Line sync polarity inversion |
| cfg_frame_sync_inv | input | 1 | Frame sync polarity inversion |
| pix_valid | input | 1 | Upstream pixel available |
| pix_red | input | 8 | Upstream red component |
| pix_green | input | 8 | Upstream green component |
| pix_blue | input | 8 | Upstream blue component |
| pix_req | output | 1 | Pixel request, one clock ahead of data-enable |
| line_sync | output | 1 | Line sync |
| frame_sync | output | 1 | Frame sync |
| de | output | 1 | Data-enable |
| rgb_out | output | 24 | Colour bus |
| pos_x | output | 11 | Pixel index within the active line |
| pos_y | output | 10 | Active line index |
| underflow | output | 1 | Sticky starvation flag |

## Verification
The bench targets the encodings that differ between fields. A design that treated a minus-one field as a plain count would shift every later span by one clock or one line. The bench also changes the configuration in the middle of a frame. Loading it early would shorten or stretch that frame, and a request computed from the old settings would miss or misplace the first pixel of the new frame. The data-enable-only setting, with zero porches and a vertical back porch of zero, catches a design that mishandles zero-length spans or miscounts the 45-clock and 16-line gaps. Starved requests check that black is sent and that the flag stays set after valid data returns.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

    parameter int COLOR_W = 8;
    parameter int HA_W    = 11;
    parameter int VA_W    = 10;
    parameter int HFP_W   = 10;
    parameter int HSW_W   = 6;
    parameter int HBP_W   = 8;
    parameter int VFP_W   = 8;
    parameter int VSW_W   = 6;
    parameter int VBP_W   = 8;

    localparam int HC_W  = HA_W + 2;
    localparam int VC_W  = VA_W + 2;
    localparam int RGB_W = 3 * COLOR_W;

    // Working timing set; the *_m1 fields hold the span length minus one
    typedef struct packed {
        logic [HA_W-1:0]  h_active;
        logic [VA_W-1:0]  v_active;
        logic [HFP_W-1:0] hfp_m1;
        logic [HSW_W-1:0] hsw_m1;
        logic [HBP_W-1:0] hbp_m1;
        logic [VFP_W-1:0] vfp;
        logic [VSW_W-1:0] vsw_m1;
        logic [VBP_W-1:0] vbp;
    } timing_cfg_t;

    // Red in the top lane, blue in the bottom lane
    typedef struct packed {
        logic [COLOR_W-1:0] red;
        logic [COLOR_W-1:0] green;
        logic [COLOR_W-1:0] blue;
    } rgb_t;

    typedef struct packed {
        logic [HC_W-1:0] fp_start;
        logic [HC_W-1:0] sync_start;
        logic [HC_W-1:0] bp_start;
        logic [HC_W-1:0] last;
    } hbounds_t;

    typedef struct packed {
        logic [VC_W-1:0] act_start;
        logic [VC_W-1:0] fp_start;
        logic [VC_W-1:0] sync_start;
        logic [VC_W-1:0] last;
    } vbounds_t;

    function automatic hbounds_t calc_h(timing_cfg_t c);
        hbounds_t b;
        b.fp_start   = HC_W'(c.h_active);
        b.sync_start = b.fp_start + HC_W'(c.hfp_m1) + HC_W'(1);
        b.bp_start   = b.sync_start + HC_W'(c.hsw_m1) + HC_W'(1);
        b.last       = b.bp_start + HC_W'(c.hbp_m1);
        return b;
    endfunction

    function automatic vbounds_t calc_v(timing_cfg_t c);
        vbounds_t b;
        b.act_start  = VC_W'(c.vbp);
        b.fp_start   = b.act_start + VC_W'(c.v_active);
        b.sync_start = b.fp_start + VC_W'(c.vfp);
        b.last       = b.sync_start + VC_W'(c.vsw_m1);
        return b;
    endfunction

    // True when the given position lies in the active area of the given set
    function automatic logic pos_active(logic [HC_W-1:0] hp, logic [VC_W-1:0] vp,
                                        timing_cfg_t c);
        return (hp < HC_W'(c.h_active)) &&
               (vp >= VC_W'(c.vbp)) &&
               (vp < VC_W'(c.vbp) + VC_W'(c.v_active));
    endfunction

endpackage

// File: rtl/rtg_shadow.sv
module rtg_shadow
    import rtg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  timing_cfg_t cfg_in,
    output timing_cfg_t cfg_work
);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            cfg_work <= cfg_in;
        end
    end

endmodule

// File: rtl/rtg_hcount.sv
module rtg_hcount
    import rtg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  timing_cfg_t     cfg,
    output logic [HC_W-1:0] hc,
    output logic            line_end,
    output logic            h_act,
    output logic            h_sync
);

    hbounds_t hb;

    assign hb       = calc_h(cfg);
    assign line_end = (hc == hb.last);
    assign h_act    = (hc < hb.fp_start);
    assign h_sync   = (hc >= hb.sync_start) && (hc < hb.bp_start);

    always_ff @(posedge clk) begin
        if (rst) begin
            hc <= '0;
        end else if (run) begin
            hc <= line_end ? '0 : hc + HC_W'(1);
        end
    end

endmodule

// File: rtl/rtg_vcount.sv
module rtg_vcount
    import rtg_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            step,
    input  timing_cfg_t     cfg,
    output logic [VC_W-1:0] vc,
    output logic            last_line,
    output logic            v_act,
    output logic            v_sync,
    output logic [VA_W-1:0] y_off
);

    vbounds_t vb;

    assign vb        = calc_v(cfg);
    assign last_line = (vc == vb.last);
    assign v_act     = (vc >= vb.act_start) && (vc < vb.fp_start);
    assign v_sync    = (vc >= vb.sync_start);
    assign y_off     = VA_W'(vc - vb.act_start);

    always_ff @(posedge clk) begin
        if (rst) begin
            vc <= '0;
        end else if (step) begin
            vc <= last_line ? '0 : vc + VC_W'(1);
        end
    end

endmodule

// File: rtl/rtg_pixel.sv
module rtg_pixel
    import rtg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic valid,
    input  rgb_t pix_in,
    output rgb_t pix_out,
    output logic underflow
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_out   <= '0;
            underflow <= 1'b0;
        end else begin
            pix_out <= (req && valid) ? pix_in : '0;
            if (req && !valid) begin
                underflow <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [HA_W-1:0]    cfg_h_active,
    input  logic [VA_W-1:0]    cfg_v_active,
    input  logic [HFP_W-1:0]   cfg_hfp,
    input  logic [HSW_W-1:0]   cfg_hsw,
    input  logic [HBP_W-1:0]   cfg_hbp,
    input  logic [VFP_W-1:0]   cfg_vfp,
    input  logic [VSW_W-1:0]   cfg_vsw,
    input  logic [VBP_W-1:0]   cfg_vbp,
    input  logic               cfg_line_sync_inv,
    input  logic               cfg_frame_sync_inv,
    input  logic               pix_valid,
    input  logic [COLOR_W-1:0] pix_red,
    input  logic [COLOR_W-1:0] pix_green,
    input  logic [COLOR_W-1:0] pix_blue,
    output logic               pix_req,
    output logic               line_sync,
    output logic               frame_sync,
    output logic               de,
    output logic [RGB_W-1:0]   rgb_out,
    output logic [HA_W-1:0]    pos_x,
    output logic [VA_W-1:0]    pos_y,
    output logic               underflow
);

    timing_cfg_t     cfg_in;
    timing_cfg_t     cfg_work;
    timing_cfg_t     cfg_next;
    rgb_t            pix_in;
    rgb_t            pix_q;
    logic            started;
    logic [HC_W-1:0] hc;
    logic [VC_W-1:0] vc;
    logic [HC_W-1:0] hc_next;
    logic [VC_W-1:0] vc_next;
    logic            line_end;
    logic            last_line;
    logic            frame_wrap;
    logic            h_act;
    logic            h_sync;
    logic            v_act;
    logic            v_sync;
    logic [VA_W-1:0] y_off;

    assign cfg_in = '{
        h_active: cfg_h_active,
        v_active: cfg_v_active,
        hfp_m1:   cfg_hfp,
        hsw_m1:   cfg_hsw,
        hbp_m1:   cfg_hbp,
        vfp:      cfg_vfp,
        vsw_m1:   cfg_vsw,
        vbp:      cfg_vbp
    };

    assign pix_in = {pix_red, pix_green, pix_blue};

    // One idle clock after reset before the raster starts moving
    always_ff @(posedge clk) begin
        if (rst) begin
            started <= 1'b0;
        end else begin
            started <= 1'b1;
        end
    end

    assign frame_wrap = started && line_end && last_line;

    rtg_shadow u_shadow (
        .clk      (clk),
        .rst      (rst),
        .load     (frame_wrap),
        .cfg_in   (cfg_in),
        .cfg_work (cfg_work)
    );

    rtg_hcount u_hcount (
        .clk      (clk),
        .rst      (rst),
        .run      (started),
        .cfg      (cfg_work),
        .hc       (hc),
        .line_end (line_end),
        .h_act    (h_act),
        .h_sync   (h_sync)
    );

    rtg_vcount u_vcount (
        .clk       (clk),
        .rst       (rst),
        .step      (started && line_end),
        .cfg       (cfg_work),
        .vc        (vc),
        .last_line (last_line),
        .v_act     (v_act),
        .v_sync    (v_sync),
        .y_off     (y_off)
    );

    // Look-ahead position, using the incoming set across a frame wrap
    always_comb begin
        cfg_next = frame_wrap ? cfg_in : cfg_work;
        hc_next  = line_end ? '0 : hc + HC_W'(1);
        if (!line_end) begin
            vc_next = vc;
        end else if (last_line) begin
            vc_next = '0;
        end else begin
            vc_next = vc + VC_W'(1);
        end
    end

    assign pix_req = started ? pos_active(hc_next, vc_next, cfg_next)
                             : (h_act && v_act);

    assign de         = started && h_act && v_act;
    assign line_sync  = (started && h_sync) ^ ~cfg_line_sync_inv;
    assign frame_sync = (started && v_sync) ^ ~cfg_frame_sync_inv;
    assign pos_x      = de ? hc[HA_W-1:0] : '0;
    assign pos_y      = de ? y_off : '0;

    rtg_pixel u_pixel (
        .clk       (clk),
        .rst       (rst),
        .req       (pix_req),
        .valid     (pix_valid),
        .pix_in    (pix_in),
        .pix_out   (pix_q),
        .underflow (underflow)
    );

    assign rgb_out = pix_q;

endmodule

// File: rtl/rtg_checker.sv
module rtg_checker
    import rtg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             de,
    input logic             pix_req,
    input logic             pix_valid,
    input logic             line_sync,
    input logic             frame_sync,
    input logic             cfg_line_sync_inv,
    input logic             cfg_frame_sync_inv,
    input logic [RGB_W-1:0] rgb_out,
    input logic             underflow
);

    p_req_then_de_r5: assert property (@(posedge clk) disable iff (rst)
        pix_req |=> de);

    p_de_after_req_r5: assert property (@(posedge clk) disable iff (rst)
        de |-> $past(pix_req));

    p_black_on_starve_r7: assert property (@(posedge clk) disable iff (rst)
        (pix_req && !pix_valid) |=> (rgb_out == '0 && underflow));

    p_sticky_flag_r7: assert property (@(posedge clk) disable iff (rst)
        underflow |=> underflow);

    p_quiet_bus_r6: assert property (@(posedge clk) disable iff (rst)
        !de |-> (rgb_out == '0));

    // Active sync level equals the inversion input (R8)
    p_no_de_in_line_sync_r2: assert property (@(posedge clk) disable iff (rst)
        (line_sync == cfg_line_sync_inv) |-> !de);

    p_no_de_in_frame_sync_r3: assert property (@(posedge clk) disable iff (rst)
        (frame_sync == cfg_frame_sync_inv) |-> !de);

endmodule

bind raster_timing_gen rtg_checker u_chk (
    .clk                (clk),
    .rst                (rst),
    .de                 (de),
    .pix_req            (pix_req),
    .pix_valid          (pix_valid),
    .line_sync          (line_sync),
    .frame_sync         (frame_sync),
    .cfg_line_sync_inv  (cfg_line_sync_inv),
    .cfg_frame_sync_inv (cfg_frame_sync_inv),
    .rgb_out            (rgb_out),
    .underflow          (underflow)
);

// File: tb/raster_timing_gen_test.sv
module raster_timing_gen_test;
    import rtg_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    typedef struct {
        int ha, va, hfp, hsw, hbp, vfp, vsw, vbp;
        int linv, finv;
    } bcfg_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    bcfg_t cur;

    logic               pix_valid = 1'b0;
    logic [COLOR_W-1:0] pix_red   = '0;
    logic [COLOR_W-1:0] pix_green = '0;
    logic [COLOR_W-1:0] pix_blue  = '0;
    logic               pix_req, line_sync, frame_sync, de, underflow;
    logic [RGB_W-1:0]   rgb_out;
    logic [HA_W-1:0]    pos_x;
    logic [VA_W-1:0]    pos_y;

    int n_cmp = 0;
    int n_bad = 0;
    bit checking = 0;
    bit starve = 0;
    string ph_tag = "";
    int src_cnt = 0;

    // reference model state
    bit    m_run = 0;
    int    m_px = 0, m_ln = 0;
    bcfg_t m_w;
    int    m_rgb = 0;
    bit    m_uf = 0;

    // R10 gap measurement
    bit r10_on = 0, prev_de = 0, seen_rise = 0, gap_seen = 0;
    int lowrun = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    raster_timing_gen uut (
        .clk(clk), .rst(rst),
        .cfg_h_active(cur.ha[HA_W-1:0]), .cfg_v_active(cur.va[VA_W-1:0]),
        .cfg_hfp(cur.hfp[HFP_W-1:0]), .cfg_hsw(cur.hsw[HSW_W-1:0]),
        .cfg_hbp(cur.hbp[HBP_W-1:0]), .cfg_vfp(cur.vfp[VFP_W-1:0]),
        .cfg_vsw(cur.vsw[VSW_W-1:0]), .cfg_vbp(cur.vbp[VBP_W-1:0]),
        .cfg_line_sync_inv(cur.linv[0]), .cfg_frame_sync_inv(cur.finv[0]),
        .pix_valid(pix_valid), .pix_red(pix_red), .pix_green(pix_green),
        .pix_blue(pix_blue), .pix_req(pix_req), .line_sync(line_sync),
        .frame_sync(frame_sync), .de(de), .rgb_out(rgb_out),
        .pos_x(pos_x), .pos_y(pos_y), .underflow(underflow)
    );

    function automatic bcfg_t mk(int ha, int va, int hfp, int hsw, int hbp,
                                 int vfp, int vsw, int vbp);
        bcfg_t c;
        c.ha = ha; c.va = va; c.hfp = hfp; c.hsw = hsw; c.hbp = hbp;
        c.vfp = vfp; c.vsw = vsw; c.vbp = vbp; c.linv = 0; c.finv = 0;
        return c;
    endfunction

    function automatic int line_len(bcfg_t c);
        return c.ha + (c.hfp + 1) + (c.hsw + 1) + (c.hbp + 1);
    endfunction

    function automatic int frame_len(bcfg_t c);
        return c.vbp + c.va + c.vfp + (c.vsw + 1);
    endfunction

    function automatic bit in_area(int p, int l, bcfg_t c);
        return (p < c.ha) && (l >= c.vbp) && (l < c.vbp + c.va);
    endfunction

    function automatic bit in_lsync(int p, bcfg_t c);
        return (p >= c.ha + c.hfp + 1) && (p < c.ha + c.hfp + 1 + c.hsw + 1);
    endfunction

    function automatic bit in_fsync(int l, bcfg_t c);
        return l >= c.vbp + c.va + c.vfp;
    endfunction

    function automatic bit model_req();
        int np, nl;
        bcfg_t nc;
        if (!m_run) return in_area(m_px, m_ln, m_w);
        np = m_px + 1; nl = m_ln; nc = m_w;
        if (np == line_len(m_w)) begin
            np = 0;
            nl = m_ln + 1;
            if (nl == frame_len(m_w)) begin
                nl = 0;
                nc = cur;
            end
        end
        return in_area(np, nl, nc);
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s act=%0h exp=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_run = 0; m_px = 0; m_ln = 0; m_w = cur; m_rgb = 0; m_uf = 0;
        end else begin
            if (model_req()) begin
                if (pix_valid) m_rgb = {pix_red, pix_green, pix_blue};
                else begin m_rgb = 0; m_uf = 1; end
            end else begin
                m_rgb = 0;
            end
            if (!m_run) begin
                m_run = 1;
            end else if (m_px == line_len(m_w) - 1) begin
                m_px = 0;
                if (m_ln == frame_len(m_w) - 1) begin
                    m_ln = 0;
                    m_w = cur;
                end else begin
                    m_ln = m_ln + 1;
                end
            end else begin
                m_px = m_px + 1;
            end
        end
    end

    // compare on the falling edge, then move the pixel source
    always @(negedge clk) begin
        if (checking) begin
            bit    e_de, ls_on, fs_on;
            string t_de, t_ls, t_fs;
            e_de  = m_run && in_area(m_px, m_ln, m_w);
            ls_on = m_run && in_lsync(m_px, m_w);
            fs_on = m_run && in_fsync(m_ln, m_w);
            t_de  = (ph_tag == "") ? "R4" : ph_tag;
            t_ls  = (ph_tag != "") ? ph_tag : (cur.linv != 0 ? "R8" : "R2");
            t_fs  = (ph_tag != "") ? ph_tag : (cur.finv != 0 ? "R8" : "R3");
            chk(t_de, "de", int'(de), int'(e_de));
            chk(t_de, "pos_x", int'(pos_x), e_de ? m_px : 0);
            chk(t_de, "pos_y", int'(pos_y), e_de ? m_ln - m_w.vbp : 0);
            chk("R5", "pix_req", int'(pix_req), int'(model_req()));
            chk("R6", "rgb", int'(rgb_out), m_rgb);
            chk("R7", "underflow", int'(underflow), int'(m_uf));
            chk(t_ls, "line_sync", int'(line_sync), int'(cur.linv != 0 ? ls_on : !ls_on));
            chk(t_fs, "frame_sync", int'(frame_sync), int'(cur.finv != 0 ? fs_on : !fs_on));
            if (r10_on) begin
                if (de) begin
                    if (!prev_de && seen_rise) begin
                        // R10: 45 clocks between lines, 16 lines plus 45 clocks between frames
                        chk("R10", "blank run", lowrun, (m_ln == 0) ? 16 * 51 + 45 : 45);
                        if (m_ln == 0) gap_seen = 1;
                    end
                    if (!prev_de) seen_rise = 1;
                    lowrun = 0;
                end else begin
                    lowrun++;
                end
                prev_de = de;
            end
        end
        src_cnt++;
        pix_red   = src_cnt[7:0];
        pix_green = src_cnt[7:0] ^ 8'h5A;
        pix_blue  = ~src_cnt[7:0];
        pix_valid = starve ? (src_cnt % 5 != 2) : 1'b1;
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        cur = mk(8, 4, 1, 1, 2, 2, 1, 1);
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: idle clock right after reset
        chk("R1", "de", int'(de), 0);
        chk("R1", "pix_req", int'(pix_req), 0);
        chk("R1", "rgb", int'(rgb_out), 0);
        chk("R1", "underflow", int'(underflow), 0);
        chk("R1", "line_sync", int'(line_sync), 1);
        chk("R1", "frame_sync", int'(frame_sync), 1);
        chk("R1", "pos_x", int'(pos_x), 0);
        checking = 1;

        // R2 R3 R4 R5 R6: nominal frames
        repeat (3 * 135) @(negedge clk);

        // R8: both syncs inverted
        cur.linv = 1; cur.finv = 1;
        repeat (2 * 135) @(negedge clk);
        cur.linv = 0; cur.finv = 0;

        // R9: change mid-frame, new timing only from the next frame
        repeat (60) @(negedge clk);
        ph_tag = "R9";
        cur = mk(5, 3, 0, 0, 0, 0, 0, 0);
        repeat (135 + 4 * 32) @(negedge clk);

        // R10: data-enable-only blanking in the sync fields
        ph_tag = "R10";
        cur = mk(6, 2, 0, 42, 0, 0, 15, 0);
        repeat (1100) @(negedge clk);
        r10_on = 1;
        repeat (2 * 918) @(negedge clk);
        r10_on = 0;
        chk("R10", "frame gap seen", int'(gap_seen), 1);

        // R7: starved source
        ph_tag = "";
        cur = mk(8, 4, 1, 1, 2, 2, 1, 1);
        repeat (1000) @(negedge clk);
        starve = 1;
        repeat (400) @(negedge clk);
        starve = 0;
        repeat (150) @(negedge clk);
        chk("R7", "flag held", int'(underflow), 1);

        finish_run();
    end

endmodule